// File: doc/BRIEF.md
# Reference-Interval Oscillator Trim Calibrator

This block closes a trim loop around an on-chip oscillator. It runs on the local clock it is trimming and counts local cycles between successive edges of a mark signal that comes from a slower, trusted reference timer. The mark arrives asynchronously. Each edge is resynchronized, and at each edge the running count is captured and the counter restarts. The capture is then compared against a programmed expected count with a programmable tolerance band. A local clock that is too fast produces too many cycles, so the signed trim code is stepped down by one. A local clock that is too slow steps the code up by one. Inside the band the code holds.

The trim code drives the analog oscillator directly. An enable input starts and stops calibration. After a configurable run of consecutive in-band measurements, a lock flag reports that the loop has settled. A one-cycle strobe marks every completed comparison and comes with the captured count.

Top module: `osc_trim_cal`

## Requirements
- R1: After reset, `trim_code` is 0 (two's complement, calibrated centre), `locked` is 0, `meas_done` is 0 and `last_count` is 0.
- R2: A comparison uses the number of local clock cycles between two consecutive synchronized mark edges. This number is reported on `last_count` and saturates at 2^CNT_W-1.
- R3: If the captured count is greater than `expect_cnt + tol_cnt`, `trim_code` decreases by one.
- R4: If the captured count plus `tol_cnt` is less than `expect_cnt`, `trim_code` increases by one.
- R5: If the captured count is within `tol_cnt` of `expect_cnt` (both ends included), `trim_code` is unchanged. With `tol_cnt` = 0, only an exact match holds.
- R6: `trim_code` saturates at the most positive value (01111 for 5 bits) and at the most negative value (10000). It never wraps.
- R7: The first synchronized mark edge after `cal_en` rises only arms the loop. It makes no comparison and changes neither `trim_code` nor `last_count`.
- R8: While `cal_en` is low, mark edges are ignored, `trim_code` and `last_count` hold, and one cycle after `cal_en` falls `locked` is 0.
- R9: `locked` is set by the comparison that completes LOCK_N consecutive in-band results. Any out-of-band comparison clears `locked` and restarts the run.
- R10: Each comparison pulses `meas_done` for one cycle. `meas_done`, `trim_code`, `last_count` and `locked` update on the third rising local clock edge after `ref_mark` rises (two synchronizer stages plus one result register). `trim_code` changes only in a cycle where `meas_done` is high.
- R11: `trim_code` moves by at most one step per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local (trimmed) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Calibration enable |
| ref_mark | input | 1 | Asynchronous reference-interval mark; a rising edge ends an interval |
| expect_cnt | input | CNT_W | Expected local cycles per reference interval |
| tol_cnt | input | TOL_W | Tolerance band half-width, in cycles |
| trim_code | output | TRIM_W | Two's-complement oscillator trim |
| locked | output | 1 | Loop settled after LOCK_N in-band intervals |
| meas_done | output | 1 | One-cycle strobe per comparison |
| last_count | output | CNT_W | Count captured at the latest comparison |

## Verification
Every result is registered on the third rising local edge after `ref_mark` rises. The bench raises the mark on a falling edge and reads the old outputs two falling edges later, then reads the new outputs on the third falling edge. That places each read half a cycle clear of the edge that updates the outputs. Each interval task starts its next rise exactly P cycles after the previous rise, so the expected capture is the period the bench chose, clipped to the counter maximum. Trim and lock state follow from a model of R3 to R9 kept in the bench. A closing closed-loop run derives the period from the live trim code, which acts as the behavioural oscillator.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

   // Decision produced by the window comparator for one interval
   typedef enum logic [1:0] {
      ADJ_HOLD = 2'd0,
      ADJ_UP   = 2'd1,
      ADJ_DOWN = 2'd2
   } adj_e;

   // Number of bits needed to hold values 0..n
   function automatic int unsigned span_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
   parameter int STAGES = 2,
   parameter bit RISE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic pulse
);
   // stg[0..STAGES-1] form the synchronizer, stg[STAGES] is the history flop
   logic stg [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= 1'b0;
      else        stg[0] <= async_in;
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= 1'b0;
         else        stg[i] <= stg[i-1];
      end
   end

   if (RISE) begin : g_rise
      assign pulse = stg[STAGES-1] & ~stg[STAGES];
   end else begin : g_fall
      assign pulse = ~stg[STAGES-1] & stg[STAGES];
   end

endmodule

// File: rtl/window_counter.sv
module window_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle,
   input  logic             reload,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   // Reload with 1 so that the value seen at the next reload equals the
   // number of cycles between the two reload events.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               count <= '0;
      else if (idle)            count <= '0;
      else if (reload)          count <= CNT_W'(1);
      else if (count != CNT_MAX) count <= count + 1'b1;
   end

endmodule

// File: rtl/trim_judge.sv
module trim_judge
   import osc_trim_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int TOL_W = 8
) (
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] expect_cnt,
   input  logic [TOL_W-1:0] tol_cnt,
   output adj_e             adj
);
   localparam int EW = CNT_W + 1;

   logic [EW-1:0] cnt_x, exp_x, tol_x, upper, cnt_plus_tol;

   always_comb begin
      cnt_x        = {1'b0, count};
      exp_x        = {1'b0, expect_cnt};
      tol_x        = {{(EW-TOL_W){1'b0}}, tol_cnt};
      upper        = exp_x + tol_x;
      cnt_plus_tol = cnt_x + tol_x;
      if (cnt_x > upper)             adj = ADJ_DOWN;
      else if (cnt_plus_tol < exp_x) adj = ADJ_UP;
      else                           adj = ADJ_HOLD;
   end

endmodule

// File: rtl/trim_stepper.sv
module trim_stepper
   import osc_trim_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int TRIM_W = 5,
   parameter int LOCK_N = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              fire,
   input  adj_e              adj,
   input  logic [CNT_W-1:0]  count,
   output logic [TRIM_W-1:0] trim,
   output logic              locked,
   output logic              done,
   output logic [CNT_W-1:0]  last
);
   localparam int SW = span_bits(LOCK_N);
   localparam logic [TRIM_W-1:0] T_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
   localparam logic [TRIM_W-1:0] T_MIN = {1'b1, {(TRIM_W-1){1'b0}}};
   localparam logic [SW-1:0]     RUN_N = SW'(LOCK_N);

   logic          armed;
   logic [SW-1:0] streak, streak_nxt;

   assign streak_nxt = (streak == RUN_N) ? streak : streak + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim   <= '0;
         locked <= 1'b0;
         done   <= 1'b0;
         last   <= '0;
         armed  <= 1'b0;
         streak <= '0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            armed  <= 1'b0;
            locked <= 1'b0;
            streak <= '0;
         end else if (fire) begin
            armed <= 1'b1;
            if (armed) begin
               done <= 1'b1;
               last <= count;
               unique case (adj)
                  ADJ_DOWN: begin
                     if (trim != T_MIN) trim <= trim - 1'b1;
                     streak <= '0;
                     locked <= 1'b0;
                  end
                  ADJ_UP: begin
                     if (trim != T_MAX) trim <= trim + 1'b1;
                     streak <= '0;
                     locked <= 1'b0;
                  end
                  default: begin
                     streak <= streak_nxt;
                     locked <= (streak_nxt == RUN_N);
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal
   import osc_trim_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int TOL_W       = 8,
   parameter int TRIM_W      = 5,
   parameter int LOCK_N      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit MARK_RISE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_en,
   input  logic              ref_mark,
   input  logic [CNT_W-1:0]  expect_cnt,
   input  logic [TOL_W-1:0]  tol_cnt,
   output logic [TRIM_W-1:0] trim_code,
   output logic              locked,
   output logic              meas_done,
   output logic [CNT_W-1:0]  last_count
);
   // Elaboration-time parameter checks
   if (CNT_W < 4) begin : g_bad_cnt
      $error("osc_trim_cal: CNT_W must be at least 4");
   end
   if (TOL_W < 1 || TOL_W > CNT_W) begin : g_bad_tol
      $error("osc_trim_cal: TOL_W must be in 1..CNT_W");
   end
   if (TRIM_W < 2) begin : g_bad_trim
      $error("osc_trim_cal: TRIM_W must be at least 2");
   end
   if (LOCK_N < 1) begin : g_bad_lock
      $error("osc_trim_cal: LOCK_N must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("osc_trim_cal: SYNC_STAGES must be at least 2");
   end

   logic             mark_evt;
   logic [CNT_W-1:0] run_cnt;
   adj_e             adj;

   ref_edge_sync #(
      .STAGES (SYNC_STAGES),
      .RISE   (MARK_RISE)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ref_mark),
      .pulse    (mark_evt)
   );

   window_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .idle   (~cal_en),
      .reload (mark_evt),
      .count  (run_cnt)
   );

   trim_judge #(
      .CNT_W (CNT_W),
      .TOL_W (TOL_W)
   ) u_judge (
      .count      (run_cnt),
      .expect_cnt (expect_cnt),
      .tol_cnt    (tol_cnt),
      .adj        (adj)
   );

   trim_stepper #(
      .CNT_W  (CNT_W),
      .TRIM_W (TRIM_W),
      .LOCK_N (LOCK_N)
   ) u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cal_en),
      .fire   (mark_evt),
      .adj    (adj),
      .count  (run_cnt),
      .trim   (trim_code),
      .locked (locked),
      .done   (meas_done),
      .last   (last_count)
   );

endmodule

// File: rtl/osc_trim_cal_chk.sv
module osc_trim_cal_chk #(
   parameter int TRIM_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cal_en,
   input logic              meas_done,
   input logic              locked,
   input logic [TRIM_W-1:0] trim_code
);
   localparam logic [TRIM_W-1:0] T_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
   localparam logic [TRIM_W-1:0] T_MIN = {1'b1, {(TRIM_W-1){1'b0}}};

   assert_trim_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_code != $past(trim_code)) |-> meas_done);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      meas_done |=> !meas_done);

   assert_single_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_code == $past(trim_code)) ||
      (trim_code == $past(trim_code) + 1'b1) ||
      (trim_code == $past(trim_code) - 1'b1));

   assert_no_wrap_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(trim_code) == T_MAX) |-> (trim_code != T_MIN));

   assert_no_wrap_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(trim_code) == T_MIN) |-> (trim_code != T_MAX));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_en |=> (!meas_done && !locked));

   assert_lock_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> meas_done);

endmodule

bind osc_trim_cal osc_trim_cal_chk #(
   .TRIM_W (TRIM_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cal_en    (cal_en),
   .meas_done (meas_done),
   .locked    (locked),
   .trim_code (trim_code)
);

// File: tb/osc_trim_cal_tb_top.sv
`timescale 1ns/1ps
module osc_trim_cal_tb_top;
   localparam int CNT_W  = 12;
   localparam int TOL_W  = 8;
   localparam int TRIM_W = 5;
   localparam int LOCK_N = 4;
   localparam int CMAX   = (1 << CNT_W) - 1;
   localparam int TMAX   = (1 << (TRIM_W-1)) - 1;
   localparam int TMIN   = -(1 << (TRIM_W-1));

   // Vector table: interval length in local cycles and tolerance (expect = 100)
   localparam int NV = 14;
   localparam int V_P [NV] = '{110, 110, 90, 102, 98, 103, 100, 101, 99, 100, 100, 100, 100, 130};
   localparam int V_T [NV] = '{2,   2,   2,  2,   2,  2,   0,   0,   0,  0,   0,   0,   0,   2};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cal_en = 1'b0;
   logic              ref_mark = 1'b0;
   logic [CNT_W-1:0]  expect_cnt = '0;
   logic [TOL_W-1:0]  tol_cnt = '0;
   logic [TRIM_W-1:0] trim_code;
   logic              locked, meas_done;
   logic [CNT_W-1:0]  last_count;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   // Bench model of the requirements
   int m_trim = 0, m_streak = 0, m_last = 0;
   bit m_lock = 0, m_armed = 0, m_fired = 0;
   int pre_trim;
   bit pre_done;

   always #2 clk = ~clk;

   osc_trim_cal #(
      .CNT_W (CNT_W), .TOL_W (TOL_W), .TRIM_W (TRIM_W), .LOCK_N (LOCK_N),
      .SYNC_STAGES (2), .MARK_RISE (1'b1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .cal_en (cal_en), .ref_mark (ref_mark),
      .expect_cnt (expect_cnt), .tol_cnt (tol_cnt), .trim_code (trim_code),
      .locked (locked), .meas_done (meas_done), .last_count (last_count)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int dut_trim();
      return int'($signed(trim_code));
   endfunction

   task automatic model_step(input int p);
      int cap, e, t;
      m_fired = 0;
      if (!cal_en) return;
      if (!m_armed) begin
         m_armed = 1;
         return;
      end
      m_fired = 1;
      cap = (p > CMAX) ? CMAX : p;
      e = int'(expect_cnt);
      t = int'(tol_cnt);
      m_last = cap;
      if (cap > e + t) begin
         if (m_trim > TMIN) m_trim--;
         m_streak = 0; m_lock = 0;
      end else if (cap + t < e) begin
         if (m_trim < TMAX) m_trim++;
         m_streak = 0; m_lock = 0;
      end else begin
         if (m_streak < LOCK_N) m_streak++;
         m_lock = (m_streak >= LOCK_N);
      end
   endtask

   // One reference interval of p local cycles, measured rise to rise;
   // outputs are read on the third falling edge after the rise.
   task automatic interval(input int p, input string req);
      repeat (p - 3) @(negedge clk);
      ref_mark = 1'b1;
      @(negedge clk);
      @(negedge clk);
      pre_trim = dut_trim();
      pre_done = meas_done;
      ref_mark = 1'b0;
      @(negedge clk);
      model_step(p);
      check(req, "trim_code", dut_trim(), m_trim);
      check(req, "locked", int'(locked), int'(m_lock));
      check(req, "last_count", int'(last_count), m_last);
      check("R10", "meas_done", int'(meas_done), int'(m_fired));
   endtask

   task automatic set_cfg(input int e, input int t);
      expect_cnt = CNT_W'(e);
      tol_cnt = TOL_W'(t);
   endtask

   initial begin
      #(4.0 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "trim_code", dut_trim(), 0);
      check("R1", "locked", int'(locked), 0);
      check("R1", "meas_done", int'(meas_done), 0);
      check("R1", "last_count", int'(last_count), 0);

      // R7 arming edge after enable
      set_cfg(100, 2);
      cal_en = 1'b1;
      interval(150, "R7");

      // R10 timing of first comparison: old value at 2nd fall, new at 3rd
      interval(110, "R3");
      check("R10", "trim before third edge", pre_trim, 0);
      check("R10", "meas_done before third edge", int'(pre_done), 0);

      // Table walk: R3 R4 R5 R9
      for (int i = 0; i < NV; i++) begin
         set_cfg(100, V_T[i]);
         interval(V_P[i], "R3/R4/R5/R9 table");
      end

      // R6 lower saturation
      set_cfg(100, 2);
      for (int i = 0; i < 20; i++) interval(200, "R6 low");
      check("R6", "trim at minimum", dut_trim(), TMIN);

      // R6 upper saturation
      for (int i = 0; i < 40; i++) interval(40, "R6 high");
      check("R6", "trim at maximum", dut_trim(), TMAX);

      // R2 counter saturation
      set_cfg(4000, 0);
      interval(5000, "R2");
      check("R2", "saturated capture", int'(last_count), CMAX);

      // R9 lock after LOCK_N exact intervals
      set_cfg(100, 0);
      for (int i = 0; i < LOCK_N; i++) interval(100, "R9");
      check("R9", "locked after run", int'(locked), 1);

      // R8 disable: edges ignored, lock cleared
      @(negedge clk);
      cal_en = 1'b0;
      m_armed = 0; m_lock = 0; m_streak = 0;
      @(negedge clk);
      check("R8", "locked after disable", int'(locked), 0);
      for (int i = 0; i < 3; i++) interval(50, "R8");

      // Re-enable: first edge only arms (R7)
      cal_en = 1'b1;
      interval(300, "R7 rearm");

      // Closed loop with behavioural oscillator: period rises with trim
      set_cfg(100, 1);
      for (int i = 0; i < 30; i++) interval(100 + 2 * dut_trim(), "R3/R4 loop");
      check("R9", "loop settled trim", dut_trim(), 0);
      check("R9", "loop locked", int'(locked), 1);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule